// File: doc/BRIEF.md
# SONET Receive B1 Checker and Tributary Deinterleaver

This block sits on the receive side of an STS-48 line interface, after framing. It takes one byte per valid cycle, with a marker on the first framing byte. It follows the frame position by itself, so a marker is needed only to acquire or re-acquire alignment. Between markers it runs on from one frame to the next.

The block does four things to the stream. It checks the section BIP-8 (B1) of each frame against a parity computed over the scrambled bytes of the frame before. It removes the frame-synchronous scrambling. It sends the bytes in rotation to four byte-wide STS-12 tributary outputs, each with an odd-parity bit. For tributary A it also rebuilds the B1 byte from that tributary's own bytes. Any bit errors found in the aggregate B1 are folded into the rebuilt byte, so a monitor further down the line still sees them.

Each mismatch gives a one-cycle alarm pulse. A saturating counter adds up the mismatched bits.

Top module: `sonet_rx_b1_demux`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `out_stb`, `out_data`, `out_par`, `b1_err` and `b1_err_cnt` are all zero.
- R2: Routing.
  - An accepted byte at frame position p (position 0 is the byte carrying `in_sof`) appears one clock later on lane p mod 4.
  - Lane k occupies `out_data[8k+7:8k]`, and `out_stb[k]` pulses for that one cycle.
  - At most one strobe bit is high at a time.
  - Bytes that arrive before the first `in_sof` produce no strobe.
- R3: Descrambling.
  - Bytes at positions below `UNSCR_BYTES` are output unchanged.
  - From position `UNSCR_BYTES` onward, each byte is XORed with the next 8 bits of a key sequence, first bit in the MSB.
  - The key sequence comes from a 7-bit state loaded with all ones at position `UNSCR_BYTES`. Each step outputs state bit 6, then shifts the state left, feeding in bit6 XOR bit5.
- R4: Each `out_par[k]` makes the 9 bits {`out_par[k]`, lane k byte} hold an odd number of ones.
- R5: B1 check.
  - At position `B1_POS`, the received B1 is the input byte XOR its key.
  - This is compared with the XOR of all received (still scrambled) bytes of the previous frame.
  - `b1_err` pulses for one cycle, together with the lane-0 strobe of that byte, when the two differ.
- R6: No B1 check is made in the first frame after reset, or in a frame opened by an `in_sof` that does not fall on the expected boundary. In such a frame, lane 0 carries the descrambled B1 byte unchanged.
- R7: In a checked frame, lane 0 at position `B1_POS` carries the XOR of three values:
  - the lane-0 bytes of the previous frame, in scrambled form;
  - the computed aggregate parity;
  - the received aggregate B1.
- R8: For each mismatch, `b1_err_cnt` increases by the number of differing bits, and saturates at 2^`CNT_W`-1. At all other times it holds its value.
- R9: After `FRAME_BYTES` accepted bytes, the next accepted byte starts a new frame without `in_sof`. An `in_sof` that falls exactly on that boundary keeps the frame aligned and checked.
- R10: Cycles with `in_valid` low produce no strobe and do not advance the frame position, the descrambler or the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte is present this cycle |
| in_sof | input | 1 | Input byte is the first byte of a frame |
| in_data | input | 8 | Scrambled STS-48 byte |
| out_stb | output | 4 | One-hot strobe: the lane written this cycle |
| out_data | output | 32 | Four tributary bytes, lane k in bits 8k+7:8k |
| out_par | output | 4 | Odd parity of each tributary byte |
| b1_err | output | 1 | One-cycle pulse on an aggregate B1 mismatch |
| b1_err_cnt | output | CNT_W | Saturating count of mismatched B1 bits |

## Verification
The assertions hold on every cycle for the following:
- at most one lane strobe is high, and a strobe only follows an input byte;
- an alarm only coincides with a lane-0 write;
- the counter holds when no alarm is raised and grows, or sits at its ceiling, when one is.

Only the bench's scenarios can show the rest, because it depends on whole frames:
- the descrambled values and their parity bits;
- the parity comparison against the previous frame;
- the error pattern folded into the rebuilt tributary B1;
- the silent first frame after acquisition or a mid-frame re-acquisition;
- running on between frames without a marker.

// File: rtl/sonet_rx_pkg.sv
`timescale 1ns/1ps
// Package: types and helpers shared by the receive B1 / deinterleave block.
// Assumes a four-way byte interleave (STS-48 into four STS-12 lanes).
package sonet_rx_pkg;
    localparam int LANES = 4;
    localparam int LANE_W = $clog2(LANES);

    typedef logic [7:0] byte_t;

    // Number of set bits in a byte.
    function automatic logic [3:0] ones8(input byte_t b);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < 8; i++) n = n + {3'b000, b[i]};
        return n;
    endfunction
endpackage

// File: rtl/sonet_rx_descr.sv
`timescale 1ns/1ps
// Frame-synchronous descrambler key generator.
// Produces the key byte for the byte at frame position pos_cur.
// Positions below UNSCR_BYTES get a zero key. The 7-bit state is loaded
// with all ones for the first scrambled position.
// Assumes step is high only for accepted bytes and UNSCR_BYTES >= 1.
module sonet_rx_descr #(
    parameter int POS_W       = 16,
    parameter int UNSCR_BYTES = 144
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [POS_W-1:0] pos_cur,
    output logic [7:0]       key
);
    logic [6:0] state_q;
    logic [6:0] state_adv;
    logic [7:0] key_raw;
    logic       clear_zone;

    assign clear_zone = (pos_cur < POS_W'(UNSCR_BYTES));

    // Run the key sequence for 8 steps, MSB first.
    always_comb begin
        logic [6:0] s;
        s = state_q;
        for (int i = 0; i < 8; i++) begin
            key_raw[7-i] = s[6];
            s = {s[5:0], s[6] ^ s[5]};
        end
        state_adv = s;
    end

    assign key = clear_zone ? 8'h00 : key_raw;

    // Hold the seed through the unscrambled zone, else advance one byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= 7'h7F;
        else if (step) state_q <= clear_zone ? 7'h7F : state_adv;
    end
endmodule

// File: rtl/sonet_bip8_acc.sv
`timescale 1ns/1ps
// BIP-8 accumulator with a per-frame snapshot.
// On a frame-start byte it stores the finished parity and restarts with that byte.
// Assumes start is only high together with en.
module sonet_bip8_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       start,
    input  logic [7:0] din,
    output logic [7:0] last_bip
);
    logic [7:0] acc_q;

    // Accumulate; at a frame boundary, snapshot and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            last_bip <= '0;
        end else if (en) begin
            if (start) begin
                last_bip <= acc_q;
                acc_q    <= din;
            end else begin
                acc_q <= acc_q ^ din;
            end
        end
    end
endmodule

// File: rtl/sonet_rx_lane_reg.sv
`timescale 1ns/1ps
// Output register of one tributary: holds the byte and its odd parity.
// Assumes load pulses once per byte routed to this lane.
module sonet_rx_lane_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       par
);
    // Capture the byte and its odd-parity bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            par  <= 1'b0;
        end else if (load) begin
            dout <= din;
            par  <= ~^din;
        end
    end
endmodule

// File: rtl/sonet_rx_b1_demux.sv
`timescale 1ns/1ps
// Receive B1 checker and four-way deinterleaver (top).
// Tracks the frame position from in_sof and runs on between markers.
// Checks the descrambled B1 against the parity of the previous scrambled frame.
// Descrambles the stream and routes it to four lanes with odd parity.
// Rebuilds the lane-0 B1 with the aggregate error pattern folded in.
// Assumes B1_POS is a nonzero multiple of 4, below FRAME_BYTES and >= UNSCR_BYTES.
module sonet_rx_b1_demux
    import sonet_rx_pkg::*;
#(
    parameter int FRAME_BYTES = 38880,
    parameter int UNSCR_BYTES = 144,
    parameter int B1_POS      = 4320,
    parameter int CNT_W       = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic [7:0]             in_data,
    output logic [LANES-1:0]       out_stb,
    output logic [8*LANES-1:0]     out_data,
    output logic [LANES-1:0]       out_par,
    output logic                   b1_err,
    output logic [CNT_W-1:0]       b1_err_cnt
);
    localparam int POS_W = $clog2(FRAME_BYTES);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BYTES - 1);
    localparam logic [POS_W-1:0] B1_AT    = POS_W'(B1_POS);
    localparam logic [CNT_W:0]   CNT_MAX  = {1'b0, {CNT_W{1'b1}}};

    logic             in_frame_q;
    logic             prev_ok_q;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_cur;
    logic             accept;
    logic             frame_start;
    logic             aligned;
    logic             at_b1;
    logic             check_now;
    logic [7:0]       key;
    logic [7:0]       plain;
    logic [7:0]       agg_bip;
    logic [7:0]       trib_bip;
    logic [7:0]       mism;
    logic [7:0]       lane_byte;
    logic [LANES-1:0] lane_ld;
    logic [CNT_W:0]   cnt_sum;

    assign accept      = in_valid && (in_sof || in_frame_q);
    assign pos_cur     = in_sof ? '0 : pos_q;
    assign frame_start = accept && (pos_cur == '0);
    assign aligned     = in_frame_q && (pos_q == '0);
    assign at_b1       = accept && (pos_cur == B1_AT);
    assign check_now   = at_b1 && prev_ok_q;

    // Frame position, lock state and previous-frame validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            pos_q      <= '0;
            prev_ok_q  <= 1'b0;
        end else if (accept) begin
            in_frame_q <= 1'b1;
            pos_q      <= (pos_cur == LAST_POS) ? '0 : pos_cur + 1'b1;
            if (frame_start) prev_ok_q <= aligned;
        end
    end

    sonet_rx_descr #(.POS_W(POS_W), .UNSCR_BYTES(UNSCR_BYTES)) descr_i (
        .clk(clk), .rst_n(rst_n), .step(accept), .pos_cur(pos_cur), .key(key)
    );

    sonet_bip8_acc agg_bip_i (
        .clk(clk), .rst_n(rst_n), .en(accept), .start(frame_start),
        .din(in_data), .last_bip(agg_bip)
    );

    sonet_bip8_acc trib_bip_i (
        .clk(clk), .rst_n(rst_n), .en(accept && (pos_cur[LANE_W-1:0] == '0)),
        .start(frame_start), .din(in_data), .last_bip(trib_bip)
    );

    assign plain     = in_data ^ key;
    assign mism      = agg_bip ^ plain;
    assign lane_byte = check_now ? (trib_bip ^ mism) : plain;
    assign cnt_sum   = {1'b0, b1_err_cnt} + (CNT_W+1)'(ones8(mism));

    // Alarm pulse and saturating bit-error count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b1_err     <= 1'b0;
            b1_err_cnt <= '0;
        end else begin
            b1_err <= check_now && (mism != 8'h00);
            if (check_now && (mism != 8'h00))
                b1_err_cnt <= (cnt_sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : cnt_sum[CNT_W-1:0];
        end
    end

    // Lane strobes, one cycle after the accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) out_stb <= '0;
        else        out_stb <= lane_ld;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_ld[k] = accept && (pos_cur[LANE_W-1:0] == LANE_W'(k));
        sonet_rx_lane_reg lane_i (
            .clk(clk), .rst_n(rst_n), .load(lane_ld[k]), .din(lane_byte),
            .dout(out_data[8*k +: 8]), .par(out_par[k])
        );
    end
endmodule

// File: rtl/sonet_rx_b1_demux_chk.sv
`timescale 1ns/1ps
// Checker for sonet_rx_b1_demux: cycle-level properties of the strobes,
// the alarm pulse and the error counter. Attached by bind below.
module sonet_rx_b1_demux_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       out_stb,
    input logic             b1_err,
    input logic [CNT_W-1:0] b1_err_cnt
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    a_r2_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_stb));

    a_r10_stb_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb != 4'b0000) |-> $past(in_valid));

    a_r5_err_on_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        b1_err |-> out_stb[0]);

    a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !b1_err |-> $stable(b1_err_cnt));

    a_r8_cnt_grow: assert property (@(posedge clk) disable iff (!rst_n)
        b1_err |-> ((b1_err_cnt > $past(b1_err_cnt)) || (b1_err_cnt == MAXV)));
endmodule

bind sonet_rx_b1_demux sonet_rx_b1_demux_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_stb(out_stb),
    .b1_err(b1_err), .b1_err_cnt(b1_err_cnt)
);

// File: tb/sonet_rx_b1_demux_tb_top.sv
`timescale 1ns/1ps
// Bench: small frame configuration.
// Each frame is built from a known payload by a transmit model (scramble,
// insert B1, optionally corrupt it). Every output byte, parity bit, alarm
// and count is compared with values the model computes.
module sonet_rx_b1_demux_tb_top;
    localparam int FB    = 64;
    localparam int UNSCR = 12;
    localparam int B1P   = 16;
    localparam int CW    = 6;
    localparam int CMAX  = 63;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_sof;
    logic [7:0]  in_data;
    logic [3:0]  out_stb;
    logic [31:0] out_data;
    logic [3:0]  out_par;
    logic        b1_err;
    logic [CW-1:0] b1_err_cnt;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Transmit-model state.
    logic [7:0] tx_bip, tx_tbip;
    bit         last_full;
    int         exp_cnt;

    always #2.5 clk = ~clk;

    sonet_rx_b1_demux #(.FRAME_BYTES(FB), .UNSCR_BYTES(UNSCR), .B1_POS(B1P), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .out_stb(out_stb), .out_data(out_data), .out_par(out_par),
        .b1_err(b1_err), .b1_err_cnt(b1_err_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Key sequence from the requirement: emit bit 6, shift left, feed bit6^bit5.
    task automatic key_byte(inout logic [6:0] s, output logic [7:0] k);
        for (int i = 0; i < 8; i++) begin
            k[7-i] = s[6];
            s = {s[5:0], s[6] ^ s[5]};
        end
    endtask

    task automatic idle_cycle();
        in_valid = 1'b0; in_sof = 1'b0;
        @(posedge clk); #1;
        chk("R10 idle strobe", {28'd0, out_stb}, 32'd0);
        chk("R10 idle alarm", {31'd0, b1_err}, 32'd0);
    endtask

    // Send frame f; stop early at stop_at to model a lost frame.
    task automatic send_frame(input int f, input logic [7:0] mask, input bit use_sof, input int stop_at);
        bit valid_m;
        logic [6:0] st;
        logic [7:0] acc, tacc, plain, ins, key, sc, expd;
        bit exp_err;
        int p;
        valid_m = last_full && 1'b1;
        st = 7'h7F; acc = 8'h00; tacc = 8'h00;
        for (p = 0; p < FB && p < stop_at; p++) begin
            plain = 8'((f * 37 + p * 13 + 5) & 255);
            if (p == B1P) ins = valid_m ? (tx_bip ^ mask) : (plain ^ mask);
            else          ins = plain;
            if (p < UNSCR) begin key = 8'h00; st = 7'h7F; end
            else key_byte(st, key);
            sc = ins ^ key;
            acc = acc ^ sc;
            if (p % 4 == 0) tacc = tacc ^ sc;
            expd    = (p == B1P && valid_m) ? (tx_tbip ^ mask) : ins;
            exp_err = (p == B1P) && valid_m && (mask != 8'h00);
            if (exp_err) exp_cnt = (exp_cnt + $countones(mask) > CMAX) ? CMAX : exp_cnt + $countones(mask);
            if (p % 7 == 3) idle_cycle();
            in_valid = 1'b1; in_sof = (p == 0) && use_sof; in_data = sc;
            @(posedge clk); #1;
            in_valid = 1'b0; in_sof = 1'b0;
            chk("R2 lane strobe", {28'd0, out_stb}, 32'd1 << (p % 4));
            if (p == B1P) chk(valid_m ? "R7 rebuilt lane0 B1" : "R6 unchecked B1 passthrough",
                              {24'd0, out_data[8*(p%4) +: 8]}, {24'd0, expd});
            else          chk("R3 descrambled byte", {24'd0, out_data[8*(p%4) +: 8]}, {24'd0, expd});
            chk("R4 odd parity", {31'd0, out_par[p%4]}, {31'd0, ~^expd});
            chk(valid_m ? "R5 B1 alarm" : "R6 no alarm", {31'd0, b1_err}, {31'd0, exp_err});
            chk("R8 error count", {26'd0, b1_err_cnt}, 32'(exp_cnt));
        end
        if (p == FB) begin
            tx_bip = acc; tx_tbip = tacc; last_full = 1'b1;
        end else begin
            last_full = 1'b0;
        end
    endtask

    initial begin
        #(5 * 190000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_data = 8'h00;
        tx_bip = 8'h00; tx_tbip = 8'h00; last_full = 1'b0; exp_cnt = 0;
        repeat (4) @(posedge clk);
        #1;
        chk("R1 reset strobe", {28'd0, out_stb}, 32'd0);
        chk("R1 reset data", out_data, 32'd0);
        chk("R1 reset parity", {28'd0, out_par}, 32'd0);
        chk("R1 reset alarm", {31'd0, b1_err}, 32'd0);
        chk("R1 reset count", {26'd0, b1_err_cnt}, 32'd0);
        rst_n = 1'b1;
        // R2: bytes before any frame start are dropped.
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1; in_data = 8'(8'h5A + i);
            @(posedge clk); #1;
            in_valid = 1'b0;
            chk("R2 pre-frame no strobe", {28'd0, out_stb}, 32'd0);
        end
        send_frame(0, 8'hA5, 1'b1, FB);   // R6 first frame unchecked
        send_frame(1, 8'h00, 1'b0, FB);   // R9 run on without marker
        send_frame(2, 8'h01, 1'b1, FB);   // R9 aligned marker, single-bit error
        send_frame(3, 8'h80, 1'b0, FB);
        send_frame(4, 8'h3C, 1'b0, FB);
        send_frame(5, 8'h00, 1'b1, FB);
        send_frame(6, 8'h00, 1'b1, 30);   // frame cut short
        send_frame(7, 8'h0F, 1'b1, FB);   // R6 re-acquired, unchecked
        send_frame(8, 8'h10, 1'b0, FB);
        for (int f = 9; f < 19; f++) send_frame(f, 8'hFF, 1'b0, FB);  // R8 saturation
        chk("R8 saturated", {26'd0, b1_err_cnt}, 32'(CMAX));
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule